// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in and returns the 16-bit sum and a carry-out. It is purely combinational. It holds no state, so it has no state machine, no clock and no reset. The operand width is split into four 4-bit groups. Inside each group, every bit carry is formed directly from per-bit generate (`a & b`) and propagate (`a | b`) terms and the group's carry-in. Each group also reports a group generate and a group propagate.

A second lookahead level takes the four group generate/propagate pairs and the global carry-in. It forms every group carry-in, and the final carry-out, at the same time as a flat sum of products. No carry passes from one group into the next. The block sits on a datapath wherever a short, fixed-depth add is needed. The sum bit at each position is the operand XOR combined with the carry that the lookahead logic delivers to that position.

Top module: `cla16_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `a_in + b_in + carry_in`, with all values unsigned.
- R2: `carry_out` equals bit 16 of the 17-bit unsigned total `a_in + b_in + carry_in`.
- R3: A bit position where both operand bits are 1 sends a carry into the next position whatever carry arrives at that position.
- R4: A bit position where exactly one operand bit is 1 passes its incoming carry unchanged to the next position.
- R5: A bit position where both operand bits are 0 sends no carry to the next position, even when a carry arrives.
- R6: When every position has at least one operand bit set and no position has both set, `carry_out` equals `carry_in`.
- R7: The carry into each 4-bit group (bits 4, 8, 12) and the carry-out follow the previous group: set if that group generates, equal to the previous group carry if that group only propagates, and clear otherwise.
- R8: With all inputs at 0, both outputs are 0. The outputs follow input changes with no clock cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
Every result of this adder is due in the same cycle as the operands that produce it, because no register lies between the ports. The driver changes the operands 1 ns after a rising clock edge and pushes the expected sum and carry into the scoreboard queue. The monitor pops and compares the entry at the next falling edge, half a period later. Each operand set is therefore checked after it has settled and before the next set arrives.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int DEF_WIDTH   = 16;
    localparam int DEF_GROUP_W = 4;

    typedef struct packed {
        logic gen;
        logic prop;
    } pg_t;

    function automatic pg_t make_pg(input logic a, input logic b);
        pg_t r;
        r.gen  = a & b;
        r.prop = a | b;
        return r;
    endfunction

endpackage

// File: rtl/cla_pg_gen.sv
module cla_pg_gen
    import cla_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        pg_t t;
        assign t       = make_pg(a[i], b[i]);
        assign gen[i]  = t.gen;
        assign prop[i] = t.prop;
    end

endmodule

// File: rtl/cla_group.sv
module cla_group #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] gen,
    input  logic [GW-1:0] prop,
    input  logic          cin,
    output logic [GW-1:0] carry,
    output logic          grp_gen,
    output logic          grp_prop
);

    logic [GW:0] src;
    assign src = {gen, cin};

    // carry into bit i: OR over sources j<=i of src[j] AND prop[j..i-1]
    always_comb begin
        logic prod;
        for (int i = 0; i < GW; i++) begin
            carry[i] = 1'b0;
            for (int j = 0; j <= i; j++) begin
                prod = src[j];
                for (int k = j; k < i; k++) begin
                    prod = prod & prop[k];
                end
                carry[i] = carry[i] | prod;
            end
        end
    end

    always_comb begin
        logic prod;
        grp_gen = 1'b0;
        for (int j = 0; j < GW; j++) begin
            prod = gen[j];
            for (int k = j + 1; k < GW; k++) begin
                prod = prod & prop[k];
            end
            grp_gen = grp_gen | prod;
        end
        grp_prop = &prop;
    end

    always_comb begin
        for (int i = 0; i < GW - 1; i++) begin
            if (gen[i]) begin
                AST_GEN_FORCES_CARRY: assert (carry[i+1]) else $error("generate lost"); // R3
            end
            if (prop[i] && !gen[i]) begin
                AST_PROP_PASSES_CARRY: assert (carry[i+1] == carry[i]) else $error("propagate broken"); // R4
            end
            if (!prop[i]) begin
                AST_KILL_BLOCKS_CARRY: assert (!carry[i+1]) else $error("kill leaked"); // R5
            end
        end
    end

endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
    parameter int NG = 4
) (
    input  logic [NG-1:0] grp_gen,
    input  logic [NG-1:0] grp_prop,
    input  logic          c0,
    output logic [NG:0]   grp_carry
);

    logic [NG:0] src;
    assign src = {grp_gen, c0};

    // all group carries formed in parallel from group terms and c0
    always_comb begin
        logic prod;
        for (int i = 0; i <= NG; i++) begin
            grp_carry[i] = 1'b0;
            for (int j = 0; j <= i; j++) begin
                prod = src[j];
                for (int k = j; k < i; k++) begin
                    prod = prod & grp_prop[k];
                end
                grp_carry[i] = grp_carry[i] | prod;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < NG; k++) begin
            if (grp_gen[k]) begin
                AST_GROUP_GEN_SETS: assert (grp_carry[k+1]) else $error("group generate lost"); // R7
            end
            if (grp_prop[k] && !grp_gen[k]) begin
                AST_GROUP_PROP_PASSES: assert (grp_carry[k+1] == grp_carry[k]) else $error("group propagate broken"); // R7
            end
            if (!grp_prop[k] && !grp_gen[k]) begin
                AST_GROUP_KILL: assert (!grp_carry[k+1]) else $error("group kill leaked"); // R7
            end
        end
    end

endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
#(
    parameter int WIDTH   = DEF_WIDTH,
    parameter int GROUP_W = DEF_GROUP_W
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int NUM_GROUPS = WIDTH / GROUP_W;

    logic [WIDTH-1:0]      bit_gen;
    logic [WIDTH-1:0]      bit_prop;
    logic [WIDTH-1:0]      bit_carry;
    logic [NUM_GROUPS-1:0] grp_gen;
    logic [NUM_GROUPS-1:0] grp_prop;
    logic [NUM_GROUPS:0]   grp_carry;

    cla_pg_gen #(.WIDTH(WIDTH)) u_pg (
        .a    (a_in),
        .b    (b_in),
        .gen  (bit_gen),
        .prop (bit_prop)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        cla_group #(.GW(GROUP_W)) u_grp (
            .gen      (bit_gen[g*GROUP_W +: GROUP_W]),
            .prop     (bit_prop[g*GROUP_W +: GROUP_W]),
            .cin      (grp_carry[g]),
            .carry    (bit_carry[g*GROUP_W +: GROUP_W]),
            .grp_gen  (grp_gen[g]),
            .grp_prop (grp_prop[g])
        );
    end

    cla_lookahead #(.NG(NUM_GROUPS)) u_la (
        .grp_gen   (grp_gen),
        .grp_prop  (grp_prop),
        .c0        (carry_in),
        .grp_carry (grp_carry)
    );

    assign sum_out   = a_in ^ b_in ^ bit_carry;
    assign carry_out = grp_carry[NUM_GROUPS];

    always_comb begin
        AST_SUM_MATCH: assert ({carry_out, sum_out} == ({1'b0, a_in} + {1'b0, b_in} + (WIDTH+1)'(carry_in)))
            else $error("total mismatch"); // R1
        if (&(a_in | b_in) && !(|(a_in & b_in))) begin
            AST_FULL_PROPAGATE: assert (carry_out == carry_in) else $error("propagate chain broken"); // R6
        end
    end

endmodule

// File: tb/sim_cla16_adder.sv
module sim_cla16_adder;

    typedef struct {
        logic [15:0] a;
        logic [15:0] b;
        logic        cin;
        logic [15:0] exp_sum;
        logic        exp_cout;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum_out;
    logic        carry_out;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    cla16_adder u0 (
        .a_in      (a_in),
        .b_in      (b_in),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    task automatic drive(input logic [15:0] a, input logic [15:0] b,
                         input logic cin, input string tag);
        item_t it;
        logic [16:0] tot;
        tot = {1'b0, a} + {1'b0, b} + {16'd0, cin};
        it.a = a; it.b = b; it.cin = cin;
        it.exp_sum = tot[15:0];
        it.exp_cout = tot[16];
        it.tag = tag;
        @(posedge clk);
        #1;
        a_in = a; b_in = b; carry_in = cin;
        q.push_back(it);
    endtask

    // monitor: compare half a period after each drive
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                it = q.pop_front();
                n_checks++;
                if (sum_out !== it.exp_sum || carry_out !== it.exp_cout) begin
                    n_fail++;
                    $display("FAIL %s a=%h b=%h cin=%0d: got sum=%h cout=%0d, expected sum=%h cout=%0d",
                             it.tag, it.a, it.b, it.cin, sum_out, carry_out, it.exp_sum, it.exp_cout);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(16'h0000, 16'h0000, 1'b0, "R8 zero inputs");
        drive(16'h0008, 16'h0008, 1'b0, "R3 generate at bit 3");
        drive(16'h0080, 16'h0080, 1'b1, "R3 generate at bit 7 with cin");
        drive(16'h000F, 16'h0000, 1'b1, "R4 propagate through low group");
        drive(16'h0003, 16'h0004, 1'b1, "R4 mixed propagate");
        drive(16'h0000, 16'h0000, 1'b1, "R5 kill at bit 0");
        drive(16'h00F0, 16'h0000, 1'b1, "R5 kill before propagate run");
        drive(16'hFFFF, 16'h0000, 1'b1, "R6 full propagate cin=1");
        drive(16'hFFFF, 16'h0000, 1'b0, "R6 full propagate cin=0");
        drive(16'h5555, 16'hAAAA, 1'b1, "R6 alternating propagate");
        drive(16'h0FFF, 16'h0001, 1'b0, "R7 carry into group 3");
        drive(16'h00FF, 16'h0001, 1'b0, "R7 carry into group 2");
        drive(16'hFFF0, 16'h0010, 1'b0, "R7 group 1 generates to carry_out");
        drive(16'hF0F0, 16'h0F0F, 1'b1, "R7 interleaved groups");
        drive(16'h8000, 16'h8000, 1'b0, "R2 top-bit carry_out");
        for (int hi = 0; hi < 2; hi++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    for (int c = 0; c < 2; c++) begin
                        drive((hi == 0) ? 16'(x) : (16'hFFF0 | 16'(x)),
                              (hi == 0) ? 16'(y) : (16'h0000 | 16'(y)),
                              1'(c), "R1 R2 low-nibble sweep");
                    end
                end
            end
        end
        for (int r = 0; r < 3000; r++) begin
            drive(16'($urandom), 16'($urandom), 1'($urandom), "R1 R2 random operands");
        end
        @(posedge clk);
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule